// File: doc/BRIEF.md
# Real-Time Clock with Alarm

This block keeps wall-clock time as a 32-bit count of seconds. It runs directly from a 32.768 kHz clock. A prescaler state machine divides that clock down to a one-second tick, and the tick advances the seconds counter. A 32-bit alarm register is compared with the counter. Two event flags, one for the tick and one for the alarm, sit in a status register next to their interrupt enables. Each interrupt output is its flag gated by its enable, and it stays high until software clears the flag by writing a one to it.

Software sets up the clock through a simple single-cycle register port. A single configuration word carries the divider in its low half and a trim count in its high half. With a divider of 32767 and a trim of 0, the tick comes once per second. A nonzero trim slows the clock slightly: once every 1024 seconds, that many input clocks are swallowed. If the whole configuration word is zero, the prescaler stays stopped.

The prescaler has three states. HALT holds the counters cleared. COUNT counts input clocks up to the divider. TRIM swallows the trim clocks. The transitions are as follows. HALT goes to COUNT when the configuration becomes nonzero (start). COUNT goes to TRIM on the tick that closes each 1024-second window, provided the trim is nonzero (trim_begin). TRIM goes back to COUNT after the trim count of clocks (trim_done). Both COUNT and TRIM go to HALT when the configuration is zero (stop).

Top module: `rtc_core`

## Requirements
- R1: After reset, the alarm, counter, configuration and status registers all read 0, and both interrupt outputs are low.
- R2: Writing the counter at offset 0x04 sets the seconds value, and reading it returns the current value. The alarm register at 0x00 and the configuration register at 0x08 read back what was written.
- R3: While the configuration register is zero, no tick occurs: the counter holds and the tick flag stays clear.
- R4: With divider D in configuration bits [15:0], the counter first increments on the (D+2)th clock edge after the edge that writes the configuration. After that it increments every D+1 clocks.
- R5: With trim T in configuration bits [31:16], the interval after every 1024th tick (counting from start) is D+1+T clocks. All other intervals stay D+1.
- R6: The tick flag (status bit 1) is set on the same edge as each counter increment. irq_hz equals that flag AND the tick enable (status bit 3).
- R7: The alarm flag (status bit 0) is set one clock after the counter becomes equal to the alarm register. The cause may be a tick or a register write. The flag is not set again while the two stay equal. irq_alarm equals that flag AND the alarm enable (status bit 2).
- R8: Writing a 1 to status bit 0 or 1 clears that flag. Writing a 0 leaves the flag unchanged.
- R9: Status bits 2 and 3 are plain read/write enables. The flags are set whatever the enables hold.
- R10: Only offsets 0x00, 0x04, 0x08 and 0x10 are mapped. Any other offset reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz time-base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, taken on the rising edge |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_hz | output | 1 | Tick interrupt, level |
| irq_alarm | output | 1 | Alarm interrupt, level |

## Verification
Register writes take effect on the edge that samples the strobe. The counter and the tick flag change on the tick edge itself, D+2 edges after a configuration write out of HALT. The alarm flag follows one edge after the counter matches. The bench drives on falling edges and samples half a cycle after each rising edge. It indexes every falling edge after a write, so each result is compared at exactly the edge the requirement names, with no tolerance window. Tick spacing and the lengthened trim interval are measured as differences between the edges at which the counter changes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    typedef enum logic [1:0] {
        PS_HALT  = 2'd0,
        PS_COUNT = 2'd1,
        PS_TRIM  = 2'd2
    } ps_state_e;

    localparam int ADDR_W     = 5;
    localparam logic [ADDR_W-1:0] OFF_ALARM = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_COUNT = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_CFG   = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 5'h10;

    localparam int ST_AL  = 0;
    localparam int ST_HZ  = 1;
    localparam int ST_ALE = 2;
    localparam int ST_HZE = 3;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int TRIM_W  = 16,
    parameter int EPOCH_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DIV_W-1:0]  div,
    input  logic [TRIM_W-1:0] trim,
    output logic              tick
);
    localparam logic [EPOCH_W-1:0] EPOCH_LAST = '1;

    ps_state_e          state_q, state_d;
    logic [DIV_W-1:0]   cnt_q;
    logic [TRIM_W-1:0]  swallow_q;
    logic [EPOCH_W-1:0] epoch_q;
    logic               at_div, trim_last;

    assign at_div    = (cnt_q == div);
    assign trim_last = (swallow_q == trim - TRIM_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_HALT:  if (run) state_d = PS_COUNT;
            PS_COUNT: begin
                if (!run)
                    state_d = PS_HALT;
                else if (at_div && epoch_q == EPOCH_LAST && trim != '0)
                    state_d = PS_TRIM;
            end
            PS_TRIM: begin
                if (!run)           state_d = PS_HALT;
                else if (trim_last) state_d = PS_COUNT;
            end
            default: state_d = PS_HALT;
        endcase
    end

    always_comb begin
        tick = (state_q == PS_COUNT) && run && at_div;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            swallow_q <= '0;
            epoch_q   <= '0;
        end else begin
            case (state_q)
                PS_COUNT: begin
                    swallow_q <= '0;
                    if (tick) begin
                        cnt_q   <= '0;
                        epoch_q <= epoch_q + EPOCH_W'(1);
                    end else begin
                        cnt_q   <= cnt_q + DIV_W'(1);
                    end
                end
                PS_TRIM: begin
                    cnt_q     <= '0;
                    swallow_q <= swallow_q + TRIM_W'(1);
                end
                default: begin
                    cnt_q     <= '0;
                    swallow_q <= '0;
                    epoch_q   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              sec_wr,
    input  logic              alarm_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] sec_q,
    output logic [DATA_W-1:0] alarm_q,
    output logic              al_set
);
    logic match, match_q;

    assign match  = (sec_q == alarm_q);
    assign al_set = match && !match_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q   <= '0;
            alarm_q <= '0;
            match_q <= 1'b1;
        end else begin
            match_q <= match;
            if (sec_wr)     sec_q <= wdata;
            else if (tick)  sec_q <= sec_q + DATA_W'(1);
            if (alarm_wr)   alarm_q <= wdata;
        end
    end
endmodule

// File: rtl/rtc_status.sv
module rtc_status
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stat_wr,
    input  logic [3:0] wbits,
    input  logic       hz_set,
    input  logic       al_set,
    output logic       flag_hz,
    output logic       flag_al,
    output logic       en_hz,
    output logic       en_al,
    output logic       irq_hz,
    output logic       irq_alarm
);
    logic clr_hz, clr_al;

    assign clr_hz = stat_wr && wbits[ST_HZ];
    assign clr_al = stat_wr && wbits[ST_AL];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_hz <= 1'b0;
            flag_al <= 1'b0;
            en_hz   <= 1'b0;
            en_al   <= 1'b0;
        end else begin
            flag_hz <= hz_set || (flag_hz && !clr_hz);
            flag_al <= al_set || (flag_al && !clr_al);
            if (stat_wr) begin
                en_hz <= wbits[ST_HZE];
                en_al <= wbits[ST_ALE];
            end
        end
    end

    assign irq_hz    = flag_hz && en_hz;
    assign irq_alarm = flag_al && en_al;
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DIV_W   = 16,
    parameter int TRIM_W  = 16,
    parameter int EPOCH_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_hz,
    output logic              irq_alarm
);
    localparam int CFG_W = DIV_W + TRIM_W;

    logic [CFG_W-1:0]  cfg_q;
    logic [DATA_W-1:0] sec_q, alarm_q;
    logic              tick, al_set;
    logic              flag_hz, flag_al, en_hz, en_al;
    logic              wr_alarm, wr_count, wr_cfg, wr_stat;

    assign wr_alarm = bus_wr && (bus_addr == OFF_ALARM);
    assign wr_count = bus_wr && (bus_addr == OFF_COUNT);
    assign wr_cfg   = bus_wr && (bus_addr == OFF_CFG);
    assign wr_stat  = bus_wr && (bus_addr == OFF_STAT);

    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_cfg) cfg_q <= bus_wdata[CFG_W-1:0];
    end

    rtc_prescaler #(.DIV_W(DIV_W), .TRIM_W(TRIM_W), .EPOCH_W(EPOCH_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cfg_q != '0),
        .div   (cfg_q[DIV_W-1:0]),
        .trim  (cfg_q[DIV_W +: TRIM_W]),
        .tick  (tick)
    );

    rtc_timebase #(.DATA_W(DATA_W)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .sec_wr   (wr_count),
        .alarm_wr (wr_alarm),
        .wdata    (bus_wdata),
        .sec_q    (sec_q),
        .alarm_q  (alarm_q),
        .al_set   (al_set)
    );

    rtc_status u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_wr   (wr_stat),
        .wbits     (bus_wdata[3:0]),
        .hz_set    (tick),
        .al_set    (al_set),
        .flag_hz   (flag_hz),
        .flag_al   (flag_al),
        .en_hz     (en_hz),
        .en_al     (en_al),
        .irq_hz    (irq_hz),
        .irq_alarm (irq_alarm)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_ALARM: bus_rdata = alarm_q;
            OFF_COUNT: bus_rdata = sec_q;
            OFF_CFG:   bus_rdata = DATA_W'(cfg_q);
            OFF_STAT:  bus_rdata = {{(DATA_W-4){1'b0}}, en_hz, en_al, flag_hz, flag_al};
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
    import rtc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CFG_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wclr_hz,
    input logic              tick,
    input logic [DATA_W-1:0] sec_q,
    input logic [DATA_W-1:0] alarm_q,
    input logic [CFG_W-1:0]  cfg_q,
    input logic              flag_hz,
    input logic              flag_al
);
    logic count_wr, stat_clr_hz;
    assign count_wr    = bus_wr && (bus_addr == OFF_COUNT);
    assign stat_clr_hz = bus_wr && (bus_addr == OFF_STAT) && wclr_hz;

    a_r3_halt_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q == '0 && $past(cfg_q) == '0) |-> !tick);

    a_r4_tick_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !count_wr) |=> (sec_q == $past(sec_q) + DATA_W'(1)));

    a_r6_hz_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_hz) |-> $past(tick));

    a_r7_alarm_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_al) |-> $past(sec_q == alarm_q));

    a_r8_w1c_hz: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr_hz && !tick) |=> !flag_hz);
endmodule

bind rtc_core rtc_core_chk #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wclr_hz  (bus_wdata[1]),
    .tick     (tick),
    .sec_q    (sec_q),
    .alarm_q  (alarm_q),
    .cfg_q    (cfg_q),
    .flag_hz  (flag_hz),
    .flag_al  (flag_al)
);

// File: tb/rtc_core_tb.sv
module rtc_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_hz, irq_alarm;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;

    localparam logic [4:0] A_ALM = 5'h00, A_CNT = 5'h04, A_CFG = 5'h08, A_ST = 5'h10;

    rtc_core u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_hz(irq_hz), .irq_alarm(irq_alarm)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_vec = n_vec + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run exceeded %0d cycles, expected finish", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec = n_vec + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_now(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        read_now(a, d);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        bus_read(A_ALM, v); check("R1 alarm reset", v, 0);
        bus_read(A_CNT, v); check("R1 counter reset", v, 0);
        bus_read(A_CFG, v); check("R1 config reset", v, 0);
        bus_read(A_ST,  v); check("R1 status reset", v, 0);
        check("R1 irq outputs reset", {30'b0, irq_hz, irq_alarm}, 0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        bus_write(A_ALM, 32'h1234_5678);
        bus_write(A_CNT, 32'hCAFE_0000);
        bus_read(A_ALM, v); check("R2 alarm readback", v, 32'h1234_5678);
        bus_read(A_CNT, v); check("R2 counter readback", v, 32'hCAFE_0000);
        bus_write(5'h0C, 32'hFFFF_FFFF);
        bus_read(5'h0C, v); check("R10 unmapped reads zero", v, 0);
        bus_read(A_ALM, v); check("R10 unmapped write leaves alarm", v, 32'h1234_5678);
        bus_read(A_CNT, v); check("R10 unmapped write leaves counter", v, 32'hCAFE_0000);
        bus_read(A_CFG, v); check("R10 unmapped write leaves config", v, 0);
        bus_write(A_ST, 32'h0000_000C);
        bus_read(A_ST, v); check("R9 enables read back", v, 32'hC);
        bus_write(A_ST, 32'h0000_0000);
        bus_read(A_ST, v); check("R9 enables cleared", v, 0);
    endtask

    task automatic t_halt;
        logic [31:0] v;
        bus_write(A_CFG, 0);
        bus_write(A_CNT, 77);
        bus_write(A_ST, 32'h3);
        repeat (50) @(negedge clk);
        bus_read(A_CNT, v); check("R3 counter frozen when config zero", v, 77);
        bus_read(A_ST, v);  check("R3 no tick flag when config zero", v & 32'h2, 0);
    endtask

    task automatic t_divider;
        logic [31:0] v, prev;
        int first, second;
        first = -1; second = -1; prev = 0;
        bus_write(A_CNT, 0);
        bus_write(A_ST, 32'h3);
        bus_write(A_CFG, 32'd3);
        for (int i = 0; i < 12; i++) begin
            if (i > 0) @(negedge clk);
            read_now(A_CNT, v);
            if (v != prev) begin
                if (first < 0) first = i; else if (second < 0) second = i;
            end
            prev = v;
        end
        check("R4 first increment edge (D=3)", first, 5);
        check("R4 increment spacing D+1", second - first, 4);
        bus_write(A_CFG, 0);
        bus_read(A_ST, v);
        check("R6 tick flag set, R9 with enable clear", v, 32'h2);
        check("R6 irq_hz low when enable clear", irq_hz, 0);
        bus_write(A_ST, 32'h8);
        bus_read(A_ST, v); check("R8 writing zero keeps tick flag", v, 32'hA);
        check("R6 irq_hz high with enable", irq_hz, 1);
        bus_write(A_ST, 32'hA);
        bus_read(A_ST, v); check("R8 write one clears tick flag", v, 32'h8);
        check("R6 irq_hz low after clear", irq_hz, 0);
        bus_write(A_ST, 32'h0);
    endtask

    task automatic t_trim;
        logic [31:0] v, prev;
        int t1023, t1024, t1025, t1026;
        t1023 = 0; t1024 = 0; t1025 = 0; t1026 = 0;
        bus_write(A_CFG, 0);
        bus_write(A_CNT, 0);
        bus_write(A_CFG, (32'd5 << 16) | 32'd3);
        prev = 0;
        for (int i = 0; i < 5000; i++) begin
            bus_read(A_CNT, v);
            if (v != prev) begin
                if (v == 1023) t1023 = i;
                if (v == 1024) t1024 = i;
                if (v == 1025) t1025 = i;
                if (v == 1026) t1026 = i;
            end
            prev = v;
            if (v >= 1026) break;
        end
        check("R5 interval before window end", t1024 - t1023, 4);
        check("R5 interval after 1024th tick is D+1+T", t1025 - t1024, 9);
        check("R5 interval back to D+1", t1026 - t1025, 4);
        bus_write(A_CFG, 0);
    endtask

    task automatic t_alarm;
        logic [31:0] v;
        int hit;
        bus_write(A_CFG, 0);
        bus_write(A_ST, 32'h3);
        bus_write(A_ALM, 20);
        bus_write(A_CNT, 19);
        bus_read(A_ST, v); check("R7 no alarm flag before match", v, 0);
        bus_write(A_CNT, 20);
        read_now(A_ST, v); check("R7 alarm flag not yet on write edge", v, 0);
        @(negedge clk);
        read_now(A_ST, v); check("R7 alarm flag one cycle after match, R9 enable clear", v, 32'h1);
        check("R7 irq_alarm low with enable clear", irq_alarm, 0);
        bus_write(A_ST, 32'h4);
        bus_read(A_ST, v); check("R8 writing zero keeps alarm flag", v, 32'h5);
        check("R7 irq_alarm high with enable", irq_alarm, 1);
        bus_write(A_ST, 32'h5);
        repeat (5) @(negedge clk);
        bus_read(A_ST, v); check("R7 flag stays clear while still equal", v, 32'h4);
        check("R7 irq_alarm low after clear", irq_alarm, 0);
        bus_write(A_ALM, 32);
        bus_write(A_CNT, 30);
        bus_write(A_ST, 32'h5);
        bus_write(A_CFG, 32'd1);
        hit = 0;
        for (int i = 0; i < 40; i++) begin
            bus_read(A_ST, v);
            if (v[0]) begin hit = 1; break; end
        end
        read_now(A_CNT, v);
        check("R7 alarm from tick seen", hit, 1);
        check("R7 counter equals alarm when flag rises", v, 32);
        bus_write(A_CFG, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_map;
        t_halt;
        t_divider;
        t_trim;
        t_alarm;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule